// File: doc/BRIEF.md
# NAND Sector Program Sequencer

This block runs a complete NAND program operation for one or more sectors without processor help once started. For each sector it can send a setup command byte, a physical sector address of one to four bytes, the sector's payload bytes, the spare-area (control-code) bytes, a confirm command byte, and a status poll. Each of these stages has its own enable bit. Stages that are disabled are skipped. The stages that are enabled always run in the fixed order listed.

Payload and spare bytes arrive as 32-bit words over two independent push ports, one per area. A DMA engine fills these ports. Each port has a request output, gated by its own enable bit. The request is raised only while the operation still needs words for that area and the buffer has room. On the device side the block drives the command/address latch strobes, the write and read strobes, the chip enable and the byte bus. It watches the ready/busy line to learn when an internal program cycle has finished.

Software loads the configuration inputs and pulses `start_i`. At the end of the operation the block raises `done_o`, which stays set until it is cleared. After each status poll, the byte the device returned can be read on `status_o`.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset: `busy_o`=0, `done_o`=0, `ce_no`=1, `we_no`=1, `re_no`=1, both request outputs 0 and `io_oe_o`=0.
- R2: `stage_en_i` enables the stages: bit0 setup command, bit1 address, bit2 payload+spare, bit3 confirm command, bit4 status poll. Per sector, enabled stages run strictly in that order, and a cleared bit removes its stage.
- R3: The setup stage sends `cmd_code_i[7:0]` and the confirm stage sends `cmd_code_i[15:8]`, each with `cle_o`=1 and `ale_o`=0. `cle_o` and `ale_o` are never both high.
- R4: The address stage sends `addr_cnt_i`+1 bytes (2 means three bytes), least significant byte first, with `ale_o`=1. Sector n of an operation uses address `sect_addr_i`+n.
- R5: The data stage sends DATA_BYTES bytes from the payload buffer, then CTL_BYTES bytes from the spare buffer. Each 32-bit word goes out starting at bits [7:0].
- R6: The device takes a byte on the rising edge of `we_no`. `we_no` stays low for exactly T_WL cycles and high for at least T_WH cycles. `io_o`, `cle_o` and `ale_o` hold steady while `we_no` is low.
- R7: When the buffer in use is empty, `we_no` stays high and the stage waits. No byte is skipped or repeated.
- R8: A request output (bit0 payload, bit1 spare of `dreq_en_i`) is high only if its enable bit is set, words of that area are still owed to the operation, and its buffer is not full. Pushes made while no words are owed are discarded.
- R9: The status stage waits for `rb_ni` low and then high, and sends 0x70 with `cle_o`=1. It then drives `re_no` low for T_RL cycles with `io_oe_o`=0. The value of `io_i` at the rising edge of `re_no` appears on `status_o`.
- R10: Every sector repeats the enabled stages, `sect_cnt_i` times in all. A count of 0 sets `done_o` with no pin activity.
- R11: Completion sets `done_o` in the cycle `busy_o` falls. `done_clr_i` or a new start clears it. `start_i` while busy is ignored.
- R12: `ce_no` is low exactly while `busy_o` is high. While it is high, `we_no` and `re_no` stay high and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_code_i | input | 16 | Setup opcode [7:0], confirm opcode [15:8] |
| sect_addr_i | input | ADDR_W | First physical sector address |
| addr_cnt_i | input | 2 | Address bytes minus one |
| stage_en_i | input | 5 | Stage enables |
| sect_cnt_i | input | 16 | Sectors per operation |
| start_i | input | 1 | Start pulse |
| done_clr_i | input | 1 | Clear pulse for the end flag |
| done_o | output | 1 | End flag |
| busy_o | output | 1 | Operation in progress |
| status_o | output | 8 | Last status byte read |
| dreq_en_i | input | 2 | Request enables: bit0 payload, bit1 spare |
| dat_push_i | input | 1 | Payload word push |
| dat_wdata_i | input | 32 | Payload word |
| dat_dreq_o | output | 1 | Payload request |
| ctl_push_i | input | 1 | Spare word push |
| ctl_wdata_i | input | 32 | Spare word |
| ctl_dreq_o | output | 1 | Spare request |
| ce_no | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_o | output | 8 | Bus out |
| io_oe_o | output | 1 | Bus drive enable |
| io_i | input | 8 | Bus in |
| rb_ni | input | 1 | Ready (1) / busy (0) |

## Verification
A word push into a buffer and the pop of that buffer's last byte can fall in the same cycle. The buffer count must then stay unchanged, neither lost nor double counted. The bench provokes this by answering every request at once while the data stage drains, so the buffer hovers between nearly empty and full. In a second run it pushes only every 32 cycles, so a refill often lands exactly as a word is emptied. Both runs are judged on the byte stream the device model captures: every payload and spare byte must appear once, in order, with the values the bench computed.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_DATA, ST_CTL, ST_CMD2,
    ST_WBSY, ST_WRDY, ST_SRCMD, ST_SRRD, ST_NEXT
  } seq_st_e;

  localparam logic [7:0] SR_OPCODE = 8'h70;

  // first enabled stage at or after index 'from'; index 5 means none left
  function automatic seq_st_e next_stage(input int from, input logic [4:0] en);
    seq_st_e nx;
    nx = ST_NEXT;
    for (int i = 4; i >= 0; i--) begin
      if (i >= from && en[i]) begin
        case (i)
          0:       nx = ST_CMD1;
          1:       nx = ST_ADDR;
          2:       nx = ST_DATA;
          3:       nx = ST_CMD2;
          default: nx = ST_WBSY;
        endcase
      end
    end
    return nx;
  endfunction

endpackage

// File: rtl/nps_byte_fifo.sv
// Word-in, byte-out buffer. DEPTH must be a power of two, at least 2.
module nps_byte_fifo #(
  parameter int DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [31:0] wdata_i,
  output logic        full_o,
  input  logic        pop_i,
  output logic [7:0]  rbyte_o,
  output logic        empty_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [1:0]    bsel;
  logic          do_push, do_pop, word_done;

  assign full_o    = (cnt == CW'(DEPTH));
  assign empty_o   = (cnt == '0);
  assign do_push   = push_i && !full_o;
  assign do_pop    = pop_i && !empty_o;
  assign word_done = do_pop && (bsel == 2'd3);
  assign rbyte_o   = mem[rp][{bsel, 3'b000} +: 8];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      bsel <= '0;
    end else begin
      if (do_push)   wp <= wp + PW'(1);
      if (do_pop)    bsel <= bsel + 2'd1;
      if (word_done) rp <= rp + PW'(1);
      case ({do_push, word_done})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nps_we_gen.sv
// Write-strobe generator: accepts one byte per request and shapes the low/high phases.
module nps_we_gen #(
  parameter int T_WL = 2,
  parameter int T_WH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [7:0] byte_i,
  input  logic       cle_i,
  input  logic       ale_i,
  output logic       ack_o,
  output logic       busy_o,
  output logic       we_no,
  output logic [7:0] io_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       oe_o
);
  localparam int TMAX = (T_WL > T_WH) ? T_WL : T_WH;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

  ph_e           ph;
  logic [CW-1:0] cnt;

  assign ack_o  = req_i && (ph == PH_IDLE);
  assign busy_o = (ph != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      we_no <= 1'b1;
      io_o  <= '0;
      cle_o <= 1'b0;
      ale_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (req_i) begin
          ph    <= PH_LOW;
          cnt   <= '0;
          we_no <= 1'b0;
          io_o  <= byte_i;
          cle_o <= cle_i;
          ale_o <= ale_i;
          oe_o  <= 1'b1;
        end
        PH_LOW: if (cnt == CW'(T_WL - 1)) begin
          ph    <= PH_HIGH;
          cnt   <= '0;
          we_no <= 1'b1;
        end else cnt <= cnt + CW'(1);
        default: if (cnt == CW'(T_WH - 1)) begin
          ph    <= PH_IDLE;
          cnt   <= '0;
          cle_o <= 1'b0;
          ale_o <= 1'b0;
          oe_o  <= 1'b0;
        end else cnt <= cnt + CW'(1);
      endcase
    end
  end
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int DATA_BYTES = 512,
  parameter int CTL_BYTES  = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 18,
  parameter int T_WL       = 2,
  parameter int T_WH       = 2,
  parameter int T_RL       = 3,
  parameter int T_RH       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cmd_code_i,
  input  logic [ADDR_W-1:0] sect_addr_i,
  input  logic [1:0]        addr_cnt_i,
  input  logic [4:0]        stage_en_i,
  input  logic [15:0]       sect_cnt_i,
  input  logic              start_i,
  input  logic              done_clr_i,
  output logic              done_o,
  output logic              busy_o,
  output logic [7:0]        status_o,
  input  logic [1:0]        dreq_en_i,
  input  logic              dat_push_i,
  input  logic [31:0]       dat_wdata_i,
  output logic              dat_dreq_o,
  input  logic              ctl_push_i,
  input  logic [31:0]       ctl_wdata_i,
  output logic              ctl_dreq_o,
  output logic              ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  input  logic [7:0]        io_i,
  input  logic              rb_ni
);
  import nps_pkg::*;

  localparam int DATA_WORDS = DATA_BYTES / 4;
  localparam int CTL_WORDS  = CTL_BYTES / 4;
  localparam int BCW = $clog2(DATA_BYTES);          // CTL_BYTES <= DATA_BYTES
  localparam int DLW = 16 + $clog2(DATA_WORDS + 1);
  localparam int CLW = 16 + $clog2(CTL_WORDS + 1);
  localparam int RMX = (T_RL > T_RH) ? T_RL : T_RH;
  localparam int RW  = $clog2(RMX + 1);

  seq_st_e        st;
  logic [15:0]    cmd_q;
  logic [4:0]     en_q;
  logic [1:0]     acnt_q;
  logic [15:0]    sect_left;
  logic [31:0]    cur_addr;
  logic [BCW-1:0] bcnt;
  logic [RW-1:0]  rcnt;
  logic [1:0]     rd_ph;
  logic           re_n_q, done_q;
  logic [7:0]     stat_q;
  logic [1:0]     rb_q;
  logic [DLW-1:0] dat_left;
  logic [CLW-1:0] ctl_left;

  logic       wr_req, wr_cle, wr_ale, wr_ack, wr_busy, wr_oe;
  logic [7:0] wr_byte;
  logic       dat_pop, ctl_pop, dat_empty, ctl_empty, dat_full, ctl_full;
  logic [7:0] dat_byte, ctl_byte;
  logic       dat_push_ok, ctl_push_ok;

  assign dat_push_ok = dat_push_i && (dat_left != '0) && !dat_full;
  assign ctl_push_ok = ctl_push_i && (ctl_left != '0) && !ctl_full;
  assign dat_dreq_o  = dreq_en_i[0] && (dat_left != '0) && !dat_full;
  assign ctl_dreq_o  = dreq_en_i[1] && (ctl_left != '0) && !ctl_full;

  nps_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_dat_fifo (
    .clk_i, .rst_ni, .push_i(dat_push_ok), .wdata_i(dat_wdata_i), .full_o(dat_full),
    .pop_i(dat_pop), .rbyte_o(dat_byte), .empty_o(dat_empty)
  );

  nps_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_ctl_fifo (
    .clk_i, .rst_ni, .push_i(ctl_push_ok), .wdata_i(ctl_wdata_i), .full_o(ctl_full),
    .pop_i(ctl_pop), .rbyte_o(ctl_byte), .empty_o(ctl_empty)
  );

  nps_we_gen #(.T_WL(T_WL), .T_WH(T_WH)) u_we_gen (
    .clk_i, .rst_ni, .req_i(wr_req), .byte_i(wr_byte), .cle_i(wr_cle), .ale_i(wr_ale),
    .ack_o(wr_ack), .busy_o(wr_busy), .we_no, .io_o, .cle_o, .ale_o, .oe_o(wr_oe)
  );

  always_comb begin
    wr_req  = 1'b0;
    wr_byte = 8'h00;
    wr_cle  = 1'b0;
    wr_ale  = 1'b0;
    dat_pop = 1'b0;
    ctl_pop = 1'b0;
    case (st)
      ST_CMD1:  begin wr_req = 1'b1; wr_byte = cmd_q[7:0];  wr_cle = 1'b1; end
      ST_ADDR:  begin wr_req = 1'b1; wr_byte = cur_addr[{bcnt[1:0], 3'b000} +: 8]; wr_ale = 1'b1; end
      ST_DATA:  begin wr_req = !dat_empty; wr_byte = dat_byte; dat_pop = wr_ack; end
      ST_CTL:   begin wr_req = !ctl_empty; wr_byte = ctl_byte; ctl_pop = wr_ack; end
      ST_CMD2:  begin wr_req = 1'b1; wr_byte = cmd_q[15:8]; wr_cle = 1'b1; end
      ST_SRCMD: begin wr_req = 1'b1; wr_byte = SR_OPCODE;   wr_cle = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cmd_q     <= '0;
      en_q      <= '0;
      acnt_q    <= '0;
      sect_left <= '0;
      cur_addr  <= '0;
      bcnt      <= '0;
      rcnt      <= '0;
      rd_ph     <= '0;
      re_n_q    <= 1'b1;
      done_q    <= 1'b0;
      stat_q    <= '0;
      rb_q      <= 2'b11;
      dat_left  <= '0;
      ctl_left  <= '0;
    end else begin
      rb_q <= {rb_q[0], rb_ni};
      if (dat_push_ok) dat_left <= dat_left - DLW'(1);
      if (ctl_push_ok) ctl_left <= ctl_left - CLW'(1);
      if (done_clr_i)  done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          if (sect_cnt_i == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q    <= 1'b0;
            cmd_q     <= cmd_code_i;
            en_q      <= stage_en_i;
            acnt_q    <= addr_cnt_i;
            sect_left <= sect_cnt_i;
            cur_addr  <= 32'(sect_addr_i);
            bcnt      <= '0;
            dat_left  <= stage_en_i[2] ? DLW'(sect_cnt_i) * DLW'(DATA_WORDS) : '0;
            ctl_left  <= stage_en_i[2] ? CLW'(sect_cnt_i) * CLW'(CTL_WORDS)  : '0;
            st        <= next_stage(0, stage_en_i);
          end
        end
        ST_CMD1: if (wr_ack) st <= next_stage(1, en_q);
        ST_ADDR: if (wr_ack) begin
          if (bcnt[1:0] == acnt_q) begin
            bcnt <= '0;
            st   <= next_stage(2, en_q);
          end else bcnt <= bcnt + BCW'(1);
        end
        ST_DATA: if (wr_ack) begin
          if (bcnt == BCW'(DATA_BYTES - 1)) begin
            bcnt <= '0;
            st   <= ST_CTL;
          end else bcnt <= bcnt + BCW'(1);
        end
        ST_CTL: if (wr_ack) begin
          if (bcnt == BCW'(CTL_BYTES - 1)) begin
            bcnt <= '0;
            st   <= next_stage(3, en_q);
          end else bcnt <= bcnt + BCW'(1);
        end
        ST_CMD2:  if (wr_ack) st <= next_stage(4, en_q);
        ST_WBSY:  if (!rb_q[1]) st <= ST_WRDY;
        ST_WRDY:  if (rb_q[1])  st <= ST_SRCMD;
        ST_SRCMD: if (wr_ack) begin
          st    <= ST_SRRD;
          rd_ph <= 2'd0;
        end
        ST_SRRD: if (!wr_busy) begin
          case (rd_ph)
            2'd0: begin
              re_n_q <= 1'b0;
              rcnt   <= '0;
              rd_ph  <= 2'd1;
            end
            2'd1: if (rcnt == RW'(T_RL - 1)) begin
              stat_q <= io_i;
              re_n_q <= 1'b1;
              rcnt   <= '0;
              rd_ph  <= 2'd2;
            end else rcnt <= rcnt + RW'(1);
            default: if (rcnt == RW'(T_RH - 1)) begin
              rcnt  <= '0;
              rd_ph <= 2'd0;
              st    <= ST_NEXT;
            end else rcnt <= rcnt + RW'(1);
          endcase
        end
        ST_NEXT: if (!wr_busy) begin
          if (sect_left == 16'd1) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            sect_left <= sect_left - 16'd1;
            cur_addr  <= cur_addr + 32'd1;
            st        <= next_stage(0, en_q);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st != ST_IDLE);
  assign ce_no    = !busy_o;
  assign done_o   = done_q;
  assign status_o = stat_q;
  assign re_no    = re_n_q;
  assign io_oe_o  = wr_oe;
endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cle_o,
  input logic       ale_o,
  input logic       we_no,
  input logic       re_no,
  input logic       ce_no,
  input logic [7:0] io_o,
  input logic       io_oe_o,
  input logic [7:0] io_i,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       done_o
);
  // R3
  cle_ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  // R6
  we_bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && !$past(we_no)) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o)));

  // R9
  re_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);

  // R9
  status_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(re_no) |-> (status_o == $past(io_i)));

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R12
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_no |-> (we_no && re_no && !io_oe_o));
endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (.*);

// File: tb/nand_prog_seq_tb.sv
`timescale 1ns/1ps
module nand_prog_seq_tb;
  localparam int DB = 512, CB = 16, TWL = 2, TWH = 2, TRL = 3, TRH = 2, BUSY_T = 6;

  logic        clk, rst_ni;
  logic [15:0] cmd_code_i;
  logic [17:0] sect_addr_i;
  logic [1:0]  addr_cnt_i;
  logic [4:0]  stage_en_i;
  logic [15:0] sect_cnt_i;
  logic        start_i, done_clr_i, done_o, busy_o;
  logic [7:0]  status_o;
  logic [1:0]  dreq_en_i;
  logic        dat_push_i, dat_dreq_o, ctl_push_i, ctl_dreq_o;
  logic [31:0] dat_wdata_i, ctl_wdata_i;
  logic        ce_no, cle_o, ale_o, we_no, re_no, io_oe_o, rb_ni;
  logic [7:0]  io_o, io_i, dev_stat;

  initial begin clk = 1'b0; forever #2 clk = ~clk; end

  nand_prog_seq #(.DATA_BYTES(DB), .CTL_BYTES(CB), .FIFO_DEPTH(4), .ADDR_W(18),
                  .T_WL(TWL), .T_WH(TWH), .T_RL(TRL), .T_RH(TRH)) u_dut (
    .clk_i(clk), .rst_ni, .cmd_code_i, .sect_addr_i, .addr_cnt_i, .stage_en_i, .sect_cnt_i,
    .start_i, .done_clr_i, .done_o, .busy_o, .status_o, .dreq_en_i,
    .dat_push_i, .dat_wdata_i, .dat_dreq_o, .ctl_push_i, .ctl_wdata_i, .ctl_dreq_o,
    .ce_no, .cle_o, .ale_o, .we_no, .re_no, .io_o, .io_oe_o, .io_i, .rb_ni
  );

  assign io_i = re_no ? 8'h00 : dev_stat;

  typedef struct packed {
    logic [4:0]  en;
    logic [1:0]  acnt;
    logic [7:0]  scnt;
    logic [17:0] addr;
    logic [7:0]  stat;
    logic        slow;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{5'h1F,    2'd2, 8'd1, 18'h2A5C3, 8'hE0, 1'b0},
    '{5'h1F,    2'd1, 8'd2, 18'h3FFFF, 8'hC1, 1'b1},
    '{5'b01101, 2'd0, 8'd1, 18'h00000, 8'h00, 1'b0},
    '{5'b11011, 2'd3, 8'd1, 18'h12345, 8'h5A, 1'b0}
  };

  int errs = 0, nchk = 0;
  bit fin = 0;
  logic [7:0] lg_b [4096];
  logic [1:0] lg_f [4096];
  logic [7:0] ex_b [4096];
  int         ex_c [4096];
  int lg_n, ex_n, re_falls, we_min, we_max, we_run, ce_err, busy_cnt;
  int d_idx, c_idx, slow_cnt, junk_n;
  bit dreq_seen, dma_on, slow;
  logic prev_we, prev_re;

  function automatic logic [7:0] db(int g); return 8'(g * 3 + 1); endfunction
  function automatic logic [7:0] cb(int g); return 8'(g * 5 + 64); endfunction

  task automatic chk(string req, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // device model and pin monitor
  initial begin
    prev_we = 1'b1; prev_re = 1'b1; we_run = 0; busy_cnt = 0; rb_ni = 1'b1;
    forever begin
      @(negedge clk);
      if (ce_no !== !busy_o) ce_err++;
      if (dat_dreq_o || ctl_dreq_o) dreq_seen = 1'b1;
      if (!we_no) we_run++;
      else if (!prev_we) begin
        if (lg_n < 4096) begin lg_b[lg_n] = io_o; lg_f[lg_n] = {cle_o, ale_o}; end
        lg_n++;
        if (we_run < we_min) we_min = we_run;
        if (we_run > we_max) we_max = we_run;
        we_run = 0;
        if (cle_o && io_o == 8'h10) busy_cnt = BUSY_T;
      end
      if (prev_re && !re_no) re_falls++;
      prev_we = we_no;
      prev_re = re_no;
      if (busy_cnt > 0) begin rb_ni = 1'b0; busy_cnt--; end
      else rb_ni = 1'b1;
    end
  end

  // DMA model
  initial begin
    dat_push_i = 1'b0; ctl_push_i = 1'b0; dat_wdata_i = '0; ctl_wdata_i = '0; slow_cnt = 0;
    forever begin
      @(negedge clk);
      dat_push_i = 1'b0; ctl_push_i = 1'b0;
      slow_cnt++;
      if (junk_n > 0) begin
        dat_push_i = 1'b1; ctl_push_i = 1'b1;
        dat_wdata_i = 32'hDEAD_BEEF; ctl_wdata_i = 32'hBAAD_F00D;
        junk_n--;
      end else if (dma_on) begin
        if (dat_dreq_o && (!slow || slow_cnt % 32 == 0)) begin
          dat_push_i = 1'b1;
          dat_wdata_i = {db(4*d_idx+3), db(4*d_idx+2), db(4*d_idx+1), db(4*d_idx)};
          d_idx++;
        end
        if (ctl_dreq_o) begin
          ctl_push_i = 1'b1;
          ctl_wdata_i = {cb(4*c_idx+3), cb(4*c_idx+2), cb(4*c_idx+1), cb(4*c_idx)};
          c_idx++;
        end
      end
    end
  end

  task automatic ex_put(logic [7:0] b, int c);
    ex_b[ex_n] = b; ex_c[ex_n] = c; ex_n++;
  endtask

  task automatic build_exp(vec_t v);
    logic [31:0] a;
    ex_n = 0;
    for (int s = 0; s < int'(v.scnt); s++) begin
      a = 32'(v.addr) + 32'(s);
      if (v.en[0]) ex_put(8'h80, 0);
      if (v.en[1]) for (int k = 0; k <= int'(v.acnt); k++) ex_put(a[8*k +: 8], 1);
      if (v.en[2]) begin
        for (int k = 0; k < DB; k++) ex_put(db(s*DB + k), 2);
        for (int k = 0; k < CB; k++) ex_put(cb(s*CB + k), 3);
      end
      if (v.en[3]) ex_put(8'h10, 0);
      if (v.en[4]) ex_put(8'h70, 4);
    end
  endtask

  task automatic run_op(vec_t v, int restart_at, int hold);
    int mm [5];
    int n;
    logic [1:0] ef;
    cmd_code_i = 16'h1080; sect_addr_i = v.addr; addr_cnt_i = v.acnt;
    stage_en_i = v.en; sect_cnt_i = 16'(v.scnt); dev_stat = v.stat; slow = v.slow;
    build_exp(v);
    lg_n = 0; re_falls = 0; we_min = 1000000; we_max = 0; ce_err = 0;
    d_idx = 0; c_idx = 0; dreq_seen = 1'b0;
    dreq_en_i = (hold > 0) ? 2'b00 : 2'b11;
    dma_on = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R11", int'(done_o), 0, "start clears end flag");
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R8", int'(dreq_seen), 0, "request held off by enable");
      dreq_en_i = 2'b11;
    end
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      sect_cnt_i = 16'd5; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 40000) begin @(negedge clk); n++; end
    dma_on = 1'b0;
    chk("R11", int'(done_o && !busy_o), 1, "completion flag");
    chk("R2", lg_n, ex_n, "byte count");
    for (int i = 0; i < 5; i++) mm[i] = 0;
    for (int i = 0; i < lg_n && i < ex_n && i < 4096; i++) begin
      ef = (ex_c[i] == 1) ? 2'b01 : ((ex_c[i] == 0 || ex_c[i] == 4) ? 2'b10 : 2'b00);
      if (lg_b[i] !== ex_b[i] || lg_f[i] !== ef) mm[ex_c[i]]++;
    end
    chk("R3", mm[0], 0, "command byte mismatches");
    chk("R4", mm[1], 0, "address byte mismatches");
    chk(v.slow ? "R7" : "R5", mm[2], 0, "payload byte mismatches");
    chk("R5", mm[3], 0, "spare byte mismatches");
    chk("R9", mm[4], 0, "status command mismatches");
    chk("R9", re_falls, v.en[4] ? int'(v.scnt) : 0, "read strobe pulses");
    if (v.en[4]) chk("R9", int'(status_o), int'(v.stat), "latched status");
    chk("R6", we_min, TWL, "min write low width");
    chk("R6", we_max, TWL, "max write low width");
    chk("R12", ce_err, 0, "chip enable vs busy");
    if (!v.en[2]) chk("R8", int'(dreq_seen), 0, "no request without data stage");
    if (restart_at > 0) chk("R11", lg_n, ex_n, "start while busy ignored");
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; done_clr_i = 1'b0; dreq_en_i = 2'b11;
    cmd_code_i = '0; sect_addr_i = '0; addr_cnt_i = '0; stage_en_i = '0; sect_cnt_i = '0;
    dev_stat = '0; dma_on = 1'b0; slow = 1'b0; junk_n = 0; lg_n = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: {busy, done, ce#, we#, re#, dreq_d, dreq_c, oe}
    chk("R1", int'({busy_o, done_o, ce_no, we_no, re_no, dat_dreq_o, ctl_dreq_o, io_oe_o}),
        int'(8'b0011_1000), "reset state");

    for (int i = 0; i < 4; i++) run_op(VEC[i], 0, 0);

    // R11: clear pulse
    done_clr_i = 1'b1; @(negedge clk); done_clr_i = 1'b0;
    chk("R11", int'(done_o), 0, "clear pulse");

    // R10: zero sector count
    lg_n = 0; sect_cnt_i = 16'd0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", int'({done_o, busy_o}), 2, "zero count completes at once");
    chk("R10", lg_n, 0, "zero count has no bus bytes");

    // R8: pushes while nothing owed are dropped
    junk_n = 3; repeat (6) @(negedge clk);
    chk("R8", int'(dat_dreq_o || ctl_dreq_o), 0, "no request while idle");
    run_op(VEC[0], 0, 0);

    // R7/R8: request enable off stalls the data stage, then resumes
    run_op(VEC[0], 0, 300);

    // R11: second start during operation
    run_op(VEC[0], 100, 0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      errs++; nchk++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule